// File: doc/BRIEF.md
# Comparison Step Timer with Debug and Sleep Freeze

This block times a fixed series of comparator steps for an on-chip analog sensing circuit. Each step is held for a programmable number of ticks of an operating clock. That operating clock is picked from one of four source tick inputs and then divided by 1, 2, 4 or 8. The divider is a counter that produces a clock enable, so no derived clock is created. At the end of each step the block samples a comparator input and stores one result bit. After the last step it raises an interrupt flag.

Software drives the block through a small register port with four locations.

- Location 0 holds the clock controls.
- Location 1 holds the step length.
- Location 2 holds the interrupt flag and the interrupt enable.
- Location 3 starts a conversion when written and returns the result byte when read.

While the CPU is halted for debug, or while the chip sleeps, the operating clock can be frozen. During a freeze every counter holds its value. When the freeze ends, the conversion continues from exactly the point where it stopped.

Top module: `cmp_step_seq`

## Requirements
- R1: Location 0 bits [1:0] select which of `src_tick[3:0]` feeds the operating clock. Code k uses `src_tick[k]`. Ticks on the other sources have no effect.
- R2: Location 0 bits [3:2] set the divide ratio. Codes 0, 1, 2 and 3 give one operating tick for every 1, 2, 4 and 8 ticks of the selected source. The divider restarts when a conversion starts.
- R3: Location 1 holds the step length N. Each step lasts N+1 operating ticks. A conversion runs 8 steps in order, with `step_idx` counting 0 to 7. `step_done` pulses once at the end of each step. At that moment `cmp_in` is stored into bit `step_idx` of the result, which is read back at location 3.
- R4: Writing 1 to location 3 bit 0 starts a conversion and raises `step_act`. On the clock edge that ends step 7, `step_act` falls and the interrupt flag sets together. With a source that ticks every cycle, a conversion takes 8·ratio·(N+1) cycles.
- R5: The interrupt flag is location 2 bit 0. Writing 1 to that bit clears the flag and writing 0 leaves it unchanged. If a clearing write lands on the completion edge, the flag is set.
- R6: Location 2 bit 1 is the interrupt enable. `irq` is 1 exactly when both the flag and the enable are 1.
- R7: Location 0 bit 4 is the run-in-debug bit. When this bit is 0 and `dbg_mode` is high, every counter and the step position hold their values. Each frozen cycle therefore lengthens the conversion by exactly one cycle. When the bit is 1, `dbg_mode` has no effect.
- R8: Location 0 bit 5 is the keep-in-sleep bit. When this bit is 0 and `sleep_in` is high, the block freezes in the same way as in R7. When the bit is 1, `sleep_in` has no effect.
- R9: While `step_act` is high, the following are ignored:
  - writes to location 0 bits [3:0];
  - writes to location 1;
  - further start writes.
- R10: After reset every register reads 0, and `irq`, `step_act` and `step_done` are 0. Location 2 bit 7 reads back `step_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| src_tick | input | 4 | Tick enables of the four clock sources |
| dbg_mode | input | 1 | CPU is halted in debug |
| sleep_in | input | 1 | Chip is in sleep |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cmp_in | input | 1 | Comparator result stub |
| step_act | output | 1 | Conversion in progress |
| step_idx | output | 3 | Current step number |
| step_done | output | 1 | Pulse on the final tick of a step |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall on the same edge:

- the setting of the flag when the last step completes;
- a software write that clears the flag.

The bench counts cycles from the start edge to reach this. With N=2 and ratio 1, it issues the clearing write exactly 24 cycles after the start. It expects the flag to read 1 afterwards and `irq` to stay high. A second collision comes from a freeze that lands on a step boundary. The bench judges it by measuring the whole conversion length against 8·ratio·(N+1) plus the number of frozen cycles.

// File: rtl/cmp_step_seq.sv
module cmp_step_seq #(
  parameter int STEPS = 8,
  parameter int TW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    src_tick,
  input  logic          dbg_mode,
  input  logic          sleep_in,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cmp_in,
  output logic          step_act,
  output logic [$clog2(STEPS)-1:0] step_idx,
  output logic          step_done,
  output logic          irq
);
  localparam int SW = $clog2(STEPS);

  logic [1:0]       src_sel, div_sel;
  logic             run_dbg, keep_slp, flag, irq_en, busy;
  logic [TW-1:0]    tim_n, tcnt;
  logic [SW-1:0]    step;
  logic [STEPS-1:0] res;
  logic [2:0]       dcnt, dmask;

  wire frozen   = (dbg_mode & ~run_dbg) | (sleep_in & ~keep_slp);
  wire src_t    = src_tick[src_sel] & ~frozen;
  assign dmask  = {div_sel == 2'd3, div_sel[1], div_sel != 2'd0};
  wire op_tick  = src_t & (dcnt == dmask);
  wire wr_ctl   = wr_en && addr == 2'd0;
  wire wr_tim   = wr_en && addr == 2'd1;
  wire wr_int   = wr_en && addr == 2'd2;
  wire start    = wr_en && addr == 2'd3 && wdata[0] && !busy;
  wire last_stp = step == SW'(STEPS - 1);
  wire fin      = step_done & last_stp;

  assign step_done = op_tick & busy & (tcnt == tim_n);
  assign step_act  = busy;
  assign step_idx  = step;
  assign irq       = flag & irq_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              dcnt <= '0;
    else if (start)          dcnt <= '0;
    else if (src_t)          dcnt <= (dcnt == dmask) ? 3'd0 : dcnt + 3'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_sel <= '0; div_sel <= '0; run_dbg <= 1'b0; keep_slp <= 1'b0;
      tim_n <= '0; flag <= 1'b0; irq_en <= 1'b0;
    end else begin
      if (wr_ctl) begin
        if (!busy) {div_sel, src_sel} <= wdata[3:0];
        run_dbg  <= wdata[4];
        keep_slp <= wdata[5];
      end
      if (wr_tim && !busy) tim_n <= wdata[TW-1:0];
      if (wr_int) irq_en <= wdata[1];
      if (fin) flag <= 1'b1;
      else if (wr_int && wdata[0]) flag <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; step <= '0; tcnt <= '0; res <= '0;
    end else if (start) begin
      busy <= 1'b1; step <= '0; tcnt <= '0; res <= '0;
    end else if (busy && op_tick) begin
      if (tcnt == tim_n) begin
        res[step] <= cmp_in;
        tcnt      <= '0;
        if (last_stp) busy <= 1'b0;
        else          step <= step + SW'(1);
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end

  always_comb
    case (addr)
      2'd0:    rdata = DW'({keep_slp, run_dbg, div_sel, src_sel});
      2'd1:    rdata = DW'(tim_n);
      2'd2:    rdata = DW'({busy, 5'd0, irq_en, flag});
      default: rdata = DW'(res);
    endcase

  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && frozen && !start |=> $stable(tcnt) && $stable(step) && $stable(dcnt));  // R7, R8
  p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy && flag);
  p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(fin));
  p_tim_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_tim |=> $stable(tim_n));
  p_tcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tcnt <= tim_n);
endmodule

// File: tb/cmp_step_seq_bench.sv
module cmp_step_seq_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] src_tick = 4'hF;
  logic dbg_mode = 0, sleep_in = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, pat = 0;
  logic step_act, step_done, irq;
  logic [2:0] step_idx;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  cmp_step_seq u_cmp_step_seq (.clk, .rst_n, .src_tick, .dbg_mode, .sleep_in,
    .wr_en, .addr, .wdata, .rdata, .cmp_in(pat[step_idx]), .step_act,
    .step_idx, .step_done, .irq);

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
      summary();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  // start a conversion, optionally freezing via debug (kind 1) or sleep (kind 2)
  task automatic conv(int kind, int flen, output int c, output int pulses);
    c = 0; pulses = 0;
    wr(2'd3, 8'h01);
    do begin
      if (flen > 0 && c == 5) begin
        if (kind == 1) dbg_mode = 1; else sleep_in = 1;
      end
      if (c == 5 + flen) begin dbg_mode = 0; sleep_in = 0; end
      if (step_done) pulses++;
      @(negedge clk); c++;
    end while (step_act && c < 5000);
    dbg_mode = 0; sleep_in = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R10 reg", d, 0); end
    chk("R10 irq", irq, 0);
    chk("R10 act", step_act, 0);
    chk("R10 done", step_done, 0);
  endtask

  task automatic t_div();
    int c, p;
    logic [7:0] d;
    int nv[4] = '{0, 4, 2, 5};
    logic [7:0] pv[4] = '{8'hA5, 8'h3C, 8'hFF, 8'h81};
    for (int k = 0; k < 4; k++) begin
      wr(2'd0, 8'(k << 2));
      wr(2'd1, 8'(nv[k]));
      pat = pv[k];
      conv(0, 0, c, p);
      chk("R2 R4 duration", c, 8 * (1 << k) * (nv[k] + 1));
      chk("R3 step_done pulses", p, 8);
      rd(2'd3, d); chk("R3 result", d, pv[k]);
      rd(2'd2, d); chk("R4 flag set busy clear", d, 8'h01);
      wr(2'd2, 8'h01);
    end
  endtask

  task automatic t_src();
    logic [7:0] d;
    int c = 0;
    src_tick = 4'b1101;
    wr(2'd0, 8'h01); wr(2'd1, 8'h00);
    pat = 8'h5A;
    wr(2'd3, 8'h01);
    repeat (20) @(negedge clk);
    chk("R1 idle source holds act", step_act, 1);
    chk("R1 idle source holds step", step_idx, 0);
    src_tick = 4'b1111;
    while (step_act && c < 100) begin @(negedge clk); c++; end
    chk("R1 selected source drives", c, 8);
    rd(2'd3, d); chk("R1 result", d, 8'h5A);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_freeze(int kind, string req);
    int c, p;
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h04);
    conv(kind, 20, c, p);
    chk({req, " frozen extends"}, c, 84);
    chk({req, " pulses"}, p, 8);
    wr(2'd0, kind == 1 ? 8'h14 : 8'h24);
    conv(kind, 20, c, p);
    chk({req, " bypass"}, c, 64);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_flag();
    int c, p;
    logic [7:0] d;
    wr(2'd0, 8'h00); wr(2'd1, 8'd1);
    conv(0, 0, c, p);
    chk("R6 irq disabled", irq, 0);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R5 write 0 keeps flag", d[0], 1);
    wr(2'd2, 8'h02);
    chk("R6 irq enabled", irq, 1);
    wr(2'd2, 8'h03);
    rd(2'd2, d); chk("R5 w1c clears", d[0], 0);
    chk("R6 irq after clear", irq, 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    wr(2'd1, 8'd2);
    wr(2'd3, 8'h01);
    repeat (23) @(negedge clk);
    wr(2'd2, 8'h03);
    rd(2'd2, d); chk("R5 set beats clear", d, 8'h03);
    chk("R5 R6 irq on collision", irq, 1);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    int c = 3;
    wr(2'd0, 8'h00); wr(2'd1, 8'd3);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'd9);
    wr(2'd0, 8'h0F);
    wr(2'd3, 8'h01);
    while (step_act && c < 500) begin @(negedge clk); c++; end
    chk("R9 duration unchanged", c, 32);
    rd(2'd1, d); chk("R9 timing kept", d, 3);
    rd(2'd0, d); chk("R9 clock fields kept", d, 0);
    wr(2'd2, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_div();
    t_src();
    t_freeze(1, "R7");
    t_freeze(2, "R8");
    t_flag();
    t_collide();
    t_lock();
    summary();
  end
endmodule